// File: doc/BRIEF.md
# Laser Eye-Safety Fault Controller

This block is the digital supervisor that sits beside a laser driver. Analog comparators elsewhere report three conditions: the bias current has run too high, the mean optical power has run too high, or the bias has drifted outside its normal working window. The first two are safety trips. A trip that outlasts a short glitch filter turns the laser off and latches a fault flag. Only a low strobe on the active-low clear input, or a chip reset, removes that flag. The third condition is advisory. It is synchronized and reported on an alarm pin that never latches and never touches the laser.

The enable to the laser driver is also gated without delay by the clear input and by a separate force-off input. After the clear input is released, the laser is brought back only after a fixed settling delay. If a trip condition is still present at that point, the fault latches again and no light is emitted. Every asynchronous comparator flag and the clear input pass through a two-flop synchronizer before they reach the sequencing logic. The active-high synchronous `rst` models a power cycle.

Top module: `laser_safety_ctrl`

## Requirements
- R1: During and directly after `rst`, `laser_en`, `fault` and `bias_alarm` are all 0.
- R2: When `bias_over` is held high for 4 or more consecutive clock samples, `fault` goes to 1 and `laser_en` to 0 on the 7th rising edge after the first high sample is set up, and not on the 6th.
- R3: When `power_over` is held high for 4 or more consecutive samples, `fault` latches and `laser_en` drops with the same 7-edge timing as R2.
- R4: A trip input that is high for 3 or fewer consecutive samples has no effect: `fault` stays 0 and `laser_en` stays 1.
- R5: Once set, `fault` stays 1 after the trip input returns low, until `clr_n` is driven 0. `fault` reads 0 on the 3rd edge after `clr_n` falls.
- R6: While `clr_n` is 0, `laser_en` is 0 in the same cycle, with no clock edge needed.
- R7: After `clr_n` returns to 1 with no trip present, `laser_en` stays 0 through the 18th edge and becomes 1 on the 19th. That is two synchronizer edges, one entry edge and a 16-cycle delay.
- R8: If a trip condition is still present when `clr_n` is released, `fault` is 1 again by the 4th edge after release and `laser_en` never becomes 1.
- R9: `laser_off` = 1 forces `laser_en` to 0 in the same cycle and leaves `fault` unchanged. When `laser_off` returns to 0 from the running state, `laser_en` is 1 again in the same cycle, with no delay.
- R10: `bias_alarm` equals `bias_range_bad` delayed by exactly 2 edges. It does not latch, and it changes neither `laser_en` nor `fault`.
- R11: When a qualified trip and a synchronized low `clr_n` reach the sequencer on the same edge, the clear wins and `fault` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst | input | 1 | Synchronous active-high reset (power-cycle equivalent) |
| clr_n | input | 1 | Active-low fault clear and laser hold |
| laser_off | input | 1 | Force-off request, immediate |
| bias_over | input | 1 | Comparator flag: bias current excessively high (async) |
| power_over | input | 1 | Comparator flag: mean optical power excessively high (async) |
| bias_range_bad | input | 1 | Comparator flag: bias outside its normal window (async) |
| laser_en | output | 1 | Enable to the laser driver |
| fault | output | 1 | Latched safety fault |
| bias_alarm | output | 1 | Non-latching bias-window alarm |

## Verification
The latch of a newly qualified trip and the clear request can arrive at the sequencer on the same edge. The bench provokes this by lowering `clr_n` exactly four cycles after raising `bias_over`. The synchronized clear and the fourth filtered trip sample then reach the sequencer together. The bench requires `fault` to stay 0 on that edge and the next. It keeps the trip asserted while the clear is released, and it expects the fault to latch again without a single cycle of laser enable.

// File: rtl/laser_safety_pkg.sv
package laser_safety_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_TRIP = 2'd3
    } lsc_state_e;

    // Order of the asynchronous inputs inside the shared synchronizer bank.
    typedef struct packed {
        logic clr_n;
        logic range_bad;
        logic power_over;
        logic bias_over;
    } lsc_async_t;

    localparam int unsigned LSC_NUM_TRIP = 2;

    // Width of a counter that must hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= INIT;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= INIT;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/lsc_persist.sv
module lsc_persist
    import laser_safety_pkg::*;
#(
    parameter int unsigned PERSIST = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic qual
);

    localparam int unsigned CW = cnt_width(PERSIST);
    localparam logic [CW-1:0] CMAX = CW'(PERSIST);

    logic [CW-1:0] run_len;

    // Count consecutive high samples and saturate once the limit is reached.
    always_ff @(posedge clk) begin
        if (rst || !level)      run_len <= '0;
        else if (run_len != CMAX) run_len <= run_len + 1'b1;
    end

    assign qual = (run_len == CMAX);

endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
    import laser_safety_pkg::*;
#(
    parameter int unsigned DELAY = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_ok,
    input  logic       trip,
    output lsc_state_e state,
    output logic       run,
    output logic       tripped
);

    localparam int unsigned DW = cnt_width(DELAY - 1);
    localparam logic [DW-1:0] DLAST = DW'(DELAY - 1);

    lsc_state_e st_q, st_d;
    logic [DW-1:0] dly_q, dly_d;

    always_comb begin
        st_d  = st_q;
        dly_d = dly_q;
        unique case (st_q)
            ST_HOLD: begin
                if (clr_ok) begin
                    st_d  = ST_WAIT;
                    dly_d = '0;
                end
            end
            ST_WAIT: begin
                if (!clr_ok)             st_d = ST_HOLD;
                else if (trip)           st_d = ST_TRIP;
                else if (dly_q == DLAST) st_d = ST_RUN;
                else                     dly_d = dly_q + 1'b1;
            end
            ST_RUN: begin
                if (!clr_ok)   st_d = ST_HOLD;
                else if (trip) st_d = ST_TRIP;
            end
            ST_TRIP: begin
                if (!clr_ok) st_d = ST_HOLD;
            end
            default: st_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_HOLD;
            dly_q <= '0;
        end else begin
            st_q  <= st_d;
            dly_q <= dly_d;
        end
    end

    assign state   = st_q;
    assign run     = (st_q == ST_RUN);
    assign tripped = (st_q == ST_TRIP);

endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
    import laser_safety_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PERSIST     = 4,
    parameter int unsigned DELAY       = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic laser_off,
    input  logic bias_over,
    input  logic power_over,
    input  logic bias_range_bad,
    output logic laser_en,
    output logic fault,
    output logic bias_alarm
);

    lsc_async_t raw, synced;
    logic [LSC_NUM_TRIP-1:0] trip_lvl, trip_qual;
    logic clr_s, trip_any, run;
    lsc_state_e state;

    assign raw.clr_n      = clr_n;
    assign raw.range_bad  = bias_range_bad;
    assign raw.power_over = power_over;
    assign raw.bias_over  = bias_over;

    // The clear input resets to 0 so that the block starts in its hold state.
    lsc_sync #(
        .WIDTH ($bits(lsc_async_t)),
        .STAGES(SYNC_STAGES),
        .INIT  ('0)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (synced)
    );

    assign clr_s       = synced.clr_n;
    assign trip_lvl[0] = synced.bias_over;
    assign trip_lvl[1] = synced.power_over;

    for (genvar t = 0; t < LSC_NUM_TRIP; t++) begin : g_trip
        lsc_persist #(.PERSIST(PERSIST)) u_persist (
            .clk  (clk),
            .rst  (rst),
            .level(trip_lvl[t]),
            .qual (trip_qual[t])
        );
    end

    assign trip_any = |trip_qual;

    lsc_seq #(.DELAY(DELAY)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .clr_ok (clr_s),
        .trip   (trip_any),
        .state  (state),
        .run    (run),
        .tripped(fault)
    );

    // The raw clear and force-off inputs gate the enable with no clock edge.
    assign laser_en   = run && clr_n && !laser_off;
    assign bias_alarm = synced.range_bad;

endmodule

// File: rtl/laser_safety_ctrl_chk.sv
module laser_safety_ctrl_chk #(
    parameter int unsigned STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic clr_n,
    input logic laser_off,
    input logic bias_range_bad,
    input logic laser_en,
    input logic fault,
    input logic bias_alarm,
    input logic clr_s,
    input logic trip_any
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    assert_dark_when_faulted_R2: assert property (@(posedge clk) disable iff (rst)
        laser_en |-> !fault);

    assert_trip_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(trip_any));

    assert_fault_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (fault && clr_s) |=> fault);

    assert_hold_is_dark_R6: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> !laser_en);

    assert_force_off_R9: assert property (@(posedge clk) disable iff (rst)
        laser_off |-> !laser_en);

    assert_alarm_lag_R10: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'(STAGES)) |-> (bias_alarm == $past(bias_range_bad, STAGES)));

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        !clr_s |=> !fault);

endmodule

bind laser_safety_ctrl laser_safety_ctrl_chk #(.STAGES(SYNC_STAGES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .clr_n         (clr_n),
    .laser_off     (laser_off),
    .bias_range_bad(bias_range_bad),
    .laser_en      (laser_en),
    .fault         (fault),
    .bias_alarm    (bias_alarm),
    .clr_s         (clr_s),
    .trip_any      (trip_any)
);

// File: tb/laser_safety_ctrl_tb_top.sv
`timescale 1ns/100ps
module laser_safety_ctrl_tb_top;

    typedef struct {
        int    cyc;
        logic  en;
        logic  flt;
        logic  alm;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst, clr_n, laser_off, bias_over, power_over, bias_range_bad;
    logic laser_en, fault, bias_alarm;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    laser_safety_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .clr_n         (clr_n),
        .laser_off     (laser_off),
        .bias_over     (bias_over),
        .power_over    (power_over),
        .bias_range_bad(bias_range_bad),
        .laser_en      (laser_en),
        .fault         (fault),
        .bias_alarm    (bias_alarm)
    );

    // Scoreboard monitor: compare every item that falls due in this cycle.
    always begin
        @(negedge clk);
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                checks++;
                if (laser_en !== sb[i].en || fault !== sb[i].flt || bias_alarm !== sb[i].alm) begin
                    errors++;
                    $display("FAIL %s cyc=%0d actual en/fault/alarm=%b%b%b expected=%b%b%b",
                             sb[i].tag, cyc, laser_en, fault, bias_alarm,
                             sb[i].en, sb[i].flt, sb[i].alm);
                end
                sb.delete(i);
            end
        end
    end

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int k, input logic en, input logic flt,
                             input logic alm, input string tag);
        exp_t e;
        e.cyc = cyc + k;
        e.en  = en;
        e.flt = flt;
        e.alm = alm;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() != 0) go(1);
    endtask

    // Strobe the clear input, then check the settling delay (R5, R7).
    task automatic recover();
        clr_n = 1'b0;
        expect_at(0, 1'b0, fault, 1'b0, "R6");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R5");
        go(4);
        clr_n = 1'b1;
        expect_at(18, 1'b0, 1'b0, 1'b0, "R7");
        expect_at(19, 1'b1, 1'b0, 1'b0, "R7");
        go(20);
        drain();
    endtask

    initial begin
        rst = 1'b1; clr_n = 1'b1; laser_off = 1'b0;
        bias_over = 1'b0; power_over = 1'b0; bias_range_bad = 1'b0;
        go(2);
        expect_at(0, 1'b0, 1'b0, 1'b0, "R1");
        go(2);
        rst = 1'b0;
        expect_at(1, 1'b0, 1'b0, 1'b0, "R1");
        expect_at(18, 1'b0, 1'b0, 1'b0, "R7");
        expect_at(19, 1'b1, 1'b0, 1'b0, "R7");
        go(21);
        drain();

        // R2: bias trip latches after the persistence filter
        bias_over = 1'b1;
        expect_at(6, 1'b1, 1'b0, 1'b0, "R2");
        expect_at(7, 1'b0, 1'b1, 1'b0, "R2");
        go(8);
        bias_over = 1'b0;
        expect_at(1, 1'b0, 1'b1, 1'b0, "R5");
        expect_at(10, 1'b0, 1'b1, 1'b0, "R5");
        go(11);
        drain();
        recover();

        // R4: a three-sample glitch is filtered
        power_over = 1'b1;
        for (int k = 0; k <= 12; k++) expect_at(k, 1'b1, 1'b0, 1'b0, "R4");
        go(3);
        power_over = 1'b0;
        go(11);
        drain();

        // R3: power trip latches
        power_over = 1'b1;
        expect_at(6, 1'b1, 1'b0, 1'b0, "R3");
        expect_at(7, 1'b0, 1'b1, 1'b0, "R3");
        go(8);
        power_over = 1'b0;
        drain();
        recover();

        // R9: force-off is immediate and releases without delay
        laser_off = 1'b1;
        expect_at(0, 1'b0, 1'b0, 1'b0, "R9");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R9");
        go(4);
        laser_off = 1'b0;
        expect_at(0, 1'b1, 1'b0, 1'b0, "R9");
        go(1);
        drain();

        // R10: advisory alarm follows its input, two edges late
        bias_range_bad = 1'b1;
        expect_at(1, 1'b1, 1'b0, 1'b0, "R10");
        expect_at(2, 1'b1, 1'b0, 1'b1, "R10");
        expect_at(20, 1'b1, 1'b0, 1'b1, "R10");
        go(21);
        bias_range_bad = 1'b0;
        expect_at(1, 1'b1, 1'b0, 1'b1, "R10");
        expect_at(2, 1'b1, 1'b0, 1'b0, "R10");
        go(3);
        drain();

        // R11: clear and qualified trip meet at the same sequencer edge
        bias_over = 1'b1;
        expect_at(3, 1'b1, 1'b0, 1'b0, "R11");
        go(4);
        clr_n = 1'b0;
        expect_at(0, 1'b0, 1'b0, 1'b0, "R6");
        expect_at(3, 1'b0, 1'b0, 1'b0, "R11");
        expect_at(4, 1'b0, 1'b0, 1'b0, "R11");
        go(6);
        // R8: release with the trip still present
        clr_n = 1'b1;
        expect_at(3, 1'b0, 1'b0, 1'b0, "R8");
        for (int k = 4; k <= 24; k++) expect_at(k, 1'b0, 1'b1, 1'b0, "R8");
        go(26);
        drain();
        bias_over = 1'b0;
        go(6);
        recover();

        // R1: reset in the middle of operation
        rst = 1'b1;
        expect_at(0, 1'b1, 1'b0, 1'b0, "R1");
        expect_at(1, 1'b0, 1'b0, 1'b0, "R1");
        go(3);
        rst = 1'b0;
        go(2);
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule